// File: doc/BRIEF.md
# Carry-free three-layer signed-digit adder

This block adds two N-digit radix-2 signed-digit numbers. Every digit takes one of the values -1, 0 or +1, and an operand's value is the sum of digit(i) × 2^i. The block is purely combinational. It has no carry chain. Each output digit is formed by three fixed layers of small digit cells, so the logic depth stays the same at any width.

Layer one rewrites each pair of operand digits as a transfer digit and a weight digit. The transfer digit moves one position up. Layer two rewrites each weight together with the transfer arriving from the position below. Layer three adds the second-level weight to the incoming second-level transfer. The rules are chosen so that layer three can never produce a value outside one digit.

The result has N+1 digits. Digits are packed two bits each, with digit i at bits [2i+1:2i]. The codes are 00 = 0, 01 = +1 and 11 = -1.

Top module: `sd3_adder`

## Requirements
- R1: The value of `sum_o` equals the value of `a_i` plus the value of `b_i`. A value is the sum of digit(i) × 2^i, with the codes 00 = 0, 01 = +1 and 11 = -1.
- R2: Every output digit is coded 00, 01 or 11. The code 10 never appears on `sum_o`.
- R3: An input digit coded 10 is read as 0. The output is identical to the output with 00 in its place.
- R4: Output digit 0 is -1 when a0+b0 = +1, is +1 when a0+b0 = -1, and is 0 otherwise.
- R5: Output digit i depends only on operand positions i-2, i-1 and i. Changing an operand digit at any other position leaves digit i unchanged.
- R6: Negating every digit of both operands negates every output digit. Negation swaps 01 and 11 and keeps 00.
- R7: Two all-zero operands give an all-zero result.
- R8: The result is N+1 digits wide. With both operands at all +1 digits, the top digit N is +1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 2*N | First operand, digit i at bits [2i+1:2i] |
| b_i | input | 2*N | Second operand, same packing |
| sum_o | output | 2*(N+1) | Sum, N+1 digits, same packing |

## Verification
For N=5, the bench applies every pair of legal operand digit patterns. This separates arithmetic errors and illegal-code leaks in any substitution rule from mistakes in the bottom digit.

Operands with zero digits written as 10 test how the decode handles undefined codes. Paired negated operands expose any rule that is not sign-symmetric.

A perturbation test changes operand digits outside a three-position window. A transfer that is routed to the wrong position, or that travels more than one position per layer, changes the digit under test and fails this check.

// File: rtl/sd3_pkg.sv
`timescale 1ns/1ps
package sd3_pkg;

  typedef logic [1:0] sdig_t;

  localparam sdig_t SD_ZERO = 2'b00;
  localparam sdig_t SD_POS  = 2'b01;
  localparam sdig_t SD_NEG  = 2'b11;

  // layer one pushes odd pair sums up, layer two keeps them local
  typedef enum logic {RULE_PUSH, RULE_KEEP} rule_e;

  function automatic logic signed [2:0] sd_dec(sdig_t d);
    logic signed [2:0] v;
    case (d)
      SD_POS:  v = 3'sd1;
      SD_NEG:  v = -3'sd1;
      default: v = 3'sd0;  // 10 read as zero
    endcase
    return v;
  endfunction

  function automatic sdig_t sd_enc(logic signed [2:0] v);
    sdig_t d;
    if (v == 3'sd1)       d = SD_POS;
    else if (v == -3'sd1) d = SD_NEG;
    else                  d = SD_ZERO;
    return d;
  endfunction

endpackage

// File: rtl/sd3_tw_cell.sv
`timescale 1ns/1ps
module sd3_tw_cell
  import sd3_pkg::*;
#(
  parameter rule_e RULE = RULE_PUSH
) (
  input  sdig_t x_i,
  input  sdig_t y_i,
  output sdig_t t_o,
  output sdig_t w_o
);

  logic signed [2:0] pair_sum;
  logic signed [2:0] t_val;
  logic signed [2:0] w_val;

  assign pair_sum = sd_dec(x_i) + sd_dec(y_i);

  // +-2 and 0 are common to both layers; +-1 picks the rule
  generate
    if (RULE == RULE_PUSH) begin : g_push
      always_comb begin
        t_val = 3'sd0;
        w_val = 3'sd0;
        case (pair_sum)
          3'sd2:  t_val = 3'sd1;
          -3'sd2: t_val = -3'sd1;
          3'sd1: begin
            t_val = 3'sd1;
            w_val = -3'sd1;
          end
          -3'sd1: begin
            t_val = -3'sd1;
            w_val = 3'sd1;
          end
          default: ;
        endcase
      end
    end else begin : g_keep
      always_comb begin
        t_val = 3'sd0;
        w_val = 3'sd0;
        case (pair_sum)
          3'sd2:   t_val = 3'sd1;
          -3'sd2:  t_val = -3'sd1;
          3'sd1:   w_val = 3'sd1;
          -3'sd1:  w_val = -3'sd1;
          default: ;
        endcase
      end
    end
  endgenerate

  assign t_o = sd_enc(t_val);
  assign w_o = sd_enc(w_val);

endmodule

// File: rtl/sd3_sum_cell.sv
`timescale 1ns/1ps
module sd3_sum_cell
  import sd3_pkg::*;
(
  input  sdig_t x_i,
  input  sdig_t y_i,
  output sdig_t d_o
);

  logic signed [2:0] pair_sum;

  // operands never share a nonzero sign here
  assign pair_sum = sd_dec(x_i) + sd_dec(y_i);
  assign d_o      = sd_enc(pair_sum);

endmodule

// File: rtl/sd3_adder.sv
`timescale 1ns/1ps
module sd3_adder
  import sd3_pkg::*;
#(
  parameter int N = 5
) (
  input  logic [2*N-1:0]     a_i,
  input  logic [2*N-1:0]     b_i,
  output logic [2*(N+1)-1:0] sum_o
);

  localparam int NOUT = N + 1;

  sdig_t a_d  [N];
  sdig_t b_d  [N];
  sdig_t t1   [N];
  sdig_t w1   [N];
  sdig_t t2   [N];
  sdig_t w2   [NOUT];
  sdig_t sd   [NOUT];

  generate
    for (genvar i = 0; i < N; i++) begin : g_l1
      assign a_d[i] = a_i[2*i +: 2];
      assign b_d[i] = b_i[2*i +: 2];

      sd3_tw_cell #(.RULE(RULE_PUSH)) u_l1 (
        .x_i(a_d[i]),
        .y_i(b_d[i]),
        .t_o(t1[i]),
        .w_o(w1[i])
      );
    end

    for (genvar i = 0; i < N; i++) begin : g_l2
      if (i == 0) begin : g_lo
        sd3_tw_cell #(.RULE(RULE_KEEP)) u_l2 (
          .x_i(w1[i]),
          .y_i(SD_ZERO),
          .t_o(t2[i]),
          .w_o(w2[i])
        );
      end else begin : g_mid
        sd3_tw_cell #(.RULE(RULE_KEEP)) u_l2 (
          .x_i(w1[i]),
          .y_i(t1[i-1]),
          .t_o(t2[i]),
          .w_o(w2[i])
        );
      end
    end

    // top position: single incoming transfer, weight passes it through
    assign w2[N] = t1[N-1];

    for (genvar i = 0; i < NOUT; i++) begin : g_l3
      if (i == 0) begin : g_lo
        sd3_sum_cell u_l3 (
          .x_i(w2[i]),
          .y_i(SD_ZERO),
          .d_o(sd[i])
        );
      end else begin : g_up
        sd3_sum_cell u_l3 (
          .x_i(w2[i]),
          .y_i(t2[i-1]),
          .d_o(sd[i])
        );
      end
      assign sum_o[2*i +: 2] = sd[i];
    end
  endgenerate

endmodule

// File: rtl/sd3_adder_chk.sv
`timescale 1ns/1ps
module sd3_adder_chk
  import sd3_pkg::*;
#(
  parameter int N = 5
) (
  input logic [2*N-1:0]     a_i,
  input logic [2*N-1:0]     b_i,
  input logic [2*(N+1)-1:0] sum_o,
  input sdig_t              w2_i [N+1],
  input sdig_t              t2_i [N]
);

  longint va, vb, vs;
  logic   bad_code;
  logic   ovf;
  logic signed [2:0] lo_sum;

  always_comb begin
    va = 0;
    vb = 0;
    vs = 0;
    bad_code = 1'b0;
    ovf = 1'b0;
    for (int i = 0; i < N; i++) begin
      va = va + longint'(sd_dec(a_i[2*i +: 2])) * (longint'(1) << i);
      vb = vb + longint'(sd_dec(b_i[2*i +: 2])) * (longint'(1) << i);
    end
    for (int i = 0; i <= N; i++) begin
      vs = vs + longint'(sd_dec(sum_o[2*i +: 2])) * (longint'(1) << i);
      if (sum_o[2*i +: 2] == 2'b10) bad_code = 1'b1;
    end
    for (int i = 1; i <= N; i++) begin
      if (w2_i[i] != SD_ZERO && w2_i[i] == t2_i[i-1]) ovf = 1'b1;
    end
    lo_sum = sd_dec(a_i[1:0]) + sd_dec(b_i[1:0]);
  end

  always_comb begin
    assert_sum_value_R1: assert (vs == va + vb)
      else $error("sum value mismatch");
    assert_legal_out_R2: assert (!bad_code)
      else $error("illegal output digit code");
    assert_no_overflow_R2: assert (!ovf)
      else $error("final layer operands share a sign");
    assert_low_digit_R4: assert (sd_dec(sum_o[1:0]) ==
        ((lo_sum == 3'sd1 || lo_sum == -3'sd1) ? -lo_sum : 3'sd0))
      else $error("low digit rule broken");
  end

endmodule

bind sd3_adder sd3_adder_chk #(.N(N)) u_sd3_adder_chk (
  .a_i  (a_i),
  .b_i  (b_i),
  .sum_o(sum_o),
  .w2_i (w2),
  .t2_i (t2)
);

// File: tb/sd3_adder_bench.sv
`timescale 1ns/1ps
module sd3_adder_bench;

  localparam int N  = 5;
  localparam int NO = N + 1;

  logic clk;
  logic rst_n;
  logic [2*N-1:0]  a;
  logic [2*N-1:0]  b;
  logic [2*NO-1:0] s;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  sd3_adder #(.N(N)) u_sd3_adder (
    .a_i  (a),
    .b_i  (b),
    .sum_o(s)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int dval(logic [1:0] c);
    if (c == 2'b01) return 1;
    if (c == 2'b11) return -1;
    return 0;
  endfunction

  function automatic logic [1:0] dcode(int d);
    if (d == 1)  return 2'b01;
    if (d == -1) return 2'b11;
    return 2'b00;
  endfunction

  function automatic int vval(logic [2*NO-1:0] v, int nd);
    int r = 0;
    for (int i = 0; i < nd; i++) r += dval(v[2*i +: 2]) * (1 << i);
    return r;
  endfunction

  function automatic logic [2*NO-1:0] vneg(logic [2*NO-1:0] v);
    logic [2*NO-1:0] r;
    for (int i = 0; i < NO; i++) r[2*i +: 2] = dcode(-dval(v[2*i +: 2]));
    return r;
  endfunction

  function automatic logic [2*N-1:0] opnd(int k);
    logic [2*N-1:0] r;
    int t = k;
    for (int i = 0; i < N; i++) begin
      r[2*i +: 2] = dcode((t % 3) - 1);
      t = t / 3;
    end
    return r;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(logic [2*N-1:0] av, logic [2*N-1:0] bv);
    @(negedge clk);
    a = av;
    b = bv;
    #1;
  endtask

  task automatic t_reset_zero;
    wait (rst_n);
    @(negedge clk);
    #1;
    chk(s == '0, "R7 zero after reset", int'(s), 0);
    apply('0, '0);
    chk(s == '0, "R7 zero operands", int'(s), 0);
  endtask

  task automatic t_exhaustive;
    int pw = 1;
    for (int i = 0; i < N; i++) pw *= 3;
    for (int k = 0; k < pw * pw; k++) begin
      logic [2*N-1:0] av, bv;
      int lo, exp_lo;
      bit legal;
      av = opnd(k % pw);
      bv = opnd(k / pw);
      apply(av, bv);
      chk(vval(s, NO) == vval({2'b00, av}, N) + vval({2'b00, bv}, N),
          "R1 sum value", vval(s, NO),
          vval({2'b00, av}, N) + vval({2'b00, bv}, N));
      legal = 1;
      for (int i = 0; i < NO; i++) if (s[2*i +: 2] == 2'b10) legal = 0;
      chk(legal, "R2 legal codes", int'(s), 0);
      lo = dval(av[1:0]) + dval(bv[1:0]);
      exp_lo = (lo == 1 || lo == -1) ? -lo : 0;
      chk(dval(s[1:0]) == exp_lo, "R4 low digit", dval(s[1:0]), exp_lo);
    end
  endtask

  task automatic t_illegal_in;
    for (int k = 0; k < 243; k += 7) begin
      logic [2*N-1:0] av, bv, ax, bx;
      logic [2*NO-1:0] ref_s;
      av = opnd(k);
      bv = opnd(242 - k);
      ax = av;
      bx = bv;
      for (int i = 0; i < N; i++) begin
        if (ax[2*i +: 2] == 2'b00) ax[2*i +: 2] = 2'b10;
        if (bx[2*i +: 2] == 2'b00) bx[2*i +: 2] = 2'b10;
      end
      apply(av, bv);
      ref_s = s;
      apply(ax, bx);
      chk(s == ref_s, "R3 code 10 as zero", int'(s), int'(ref_s));
    end
  endtask

  task automatic t_locality;
    for (int k = 0; k < 243; k += 31) begin
      logic [2*N-1:0] av, bv, ap;
      logic [1:0] ref_d;
      av = opnd(k);
      bv = opnd((k * 5 + 17) % 243);
      for (int i = 0; i < NO; i++) begin
        for (int j = 0; j < N; j++) begin
          if (j > i || j < i - 2) begin
            apply(av, bv);
            ref_d = s[2*i +: 2];
            ap = av;
            ap[2*j +: 2] = dcode(((dval(av[2*j +: 2]) + 2) % 3) - 1);
            apply(ap, bv);
            chk(s[2*i +: 2] == ref_d, "R5 digit locality",
                int'(s[2*i +: 2]), int'(ref_d));
          end
        end
      end
    end
  endtask

  task automatic t_symmetry;
    for (int k = 0; k < 59049; k += 97) begin
      logic [2*N-1:0] av, bv;
      logic [2*NO-1:0] ref_s, na, nb;
      av = opnd(k % 243);
      bv = opnd(k / 243);
      apply(av, bv);
      ref_s = s;
      na = vneg({2'b00, av});
      nb = vneg({2'b00, bv});
      apply(na[2*N-1:0], nb[2*N-1:0]);
      chk(s == vneg(ref_s), "R6 sign symmetry", int'(s), int'(vneg(ref_s)));
    end
  endtask

  task automatic t_top_digit;
    logic [2*N-1:0] ones;
    for (int i = 0; i < N; i++) ones[2*i +: 2] = 2'b01;
    apply(ones, ones);
    chk(s[2*N +: 2] == 2'b01, "R8 top digit +1", int'(s[2*N +: 2]), 1);
    chk(vval(s, NO) == 2 * ((1 << N) - 1), "R8 max value",
        vval(s, NO), 2 * ((1 << N) - 1));
    apply(vneg({2'b00, ones})[2*N-1:0], vneg({2'b00, ones})[2*N-1:0]);
    chk(s[2*N +: 2] == 2'b11, "R8 top digit -1", int'(s[2*N +: 2]), 3);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a = '0;
    b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_zero();
    t_top_digit();
    t_illegal_in();
    t_locality();
    t_symmetry();
    t_exhaustive();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule